// File: doc/BRIEF.md
# Fuse Serial Number Generator

This block turns a 32-byte one-time-programmable fuse image into a 64-bit device serial number and a handful of decoded identification fields. Once the fuse image has been read out, the surrounding logic presents it on a wide input bus and pulses `start`. The block copies the image into its own register on that pulse, so later changes on the input bus do not affect the result.

It then steps through sixteen selected bytes, one per clock, in an interleaved order. The first eight bytes are the even-numbered bytes 8, 10, ... 22. They are fed into a reflected CRC-32 that starts at zero, and the result becomes the low serial word. The CRC register is not reset between the two passes. It continues over the odd-numbered bytes 7, 9, ... 21, so the second pass is seeded by the low word and its result becomes the high word. A valid flag marks when both words are ready.

The fuse version, process version, CPU revision and a selectable leakage byte are decoded combinationally from the captured image. These fields are available from the cycle after the start pulse.

Top module: `fuse_serial_gen`

## Requirements
- R1: After reset, `valid` is 0, both serial words are 0, and every decoded field and `leak_val` read 0.
- R2: Fuse byte k is `fuse_img[8k+7:8k]`. `serial_lo` equals the CRC of fuse bytes 8, 10, 12, 14, 16, 18, 20, 22, taken in that order and starting from a CRC register of zero.
- R3: `serial_hi` equals the CRC of fuse bytes 7, 9, 11, 13, 15, 17, 19, 21, taken in that order and starting from a CRC register equal to `serial_lo`.
- R4: The CRC step XORs the byte into bits 7:0 of the register. It then performs eight shifts to the right, XORing in 0xEDB88320 whenever the bit shifted out is 1. No final inversion is applied, so an all-zero image gives zero for both words.
- R5: Let the start pulse be sampled at edge E0. Then `valid` stays 0 through edge E15 and reads 1 after edge E16.
- R6: A start pulse clears `valid` at the following edge. A start pulse during a run aborts that run and restarts it on the new image.
- R7: `fuse_ver` is fuse byte 4 with bit 3 forced to 0.
- R8: `proc_ver` is bits 3:0 of fuse byte 6, and `cpu_rev` is bits 5:4 of fuse byte 6.
- R9: `leak_sel` values 0, 1 and 2 return fuse bytes 23, 24 and 25 on `leak_val`. The value 3 returns 0.
- R10: The image is captured only at a start pulse. Changes on `fuse_img` at other times have no effect on the serial words or on the decoded fields.
- R11: While `valid` is 1 and no start pulse arrives, `valid` and both serial words hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse: capture the image and begin generation |
| fuse_img | input | 256 | Fuse image, with byte k at bits 8k+7:8k |
| leak_sel | input | 2 | Leakage channel index |
| serial_lo | output | 32 | Low serial word |
| serial_hi | output | 32 | High serial word |
| fuse_ver | output | 8 | Fuse version field |
| proc_ver | output | 4 | Process version field |
| cpu_rev | output | 2 | CPU revision field |
| leak_val | output | 8 | Leakage byte for the selected channel |
| valid | output | 1 | Serial words are complete |

## Verification
The bench builds the block with its default parameters: a 32-byte image, groups of eight bytes, and the standard reflected polynomial. With these values the full sixteen-step sequence and the chaining from the low word into the high word are exercised exactly as the serial number is defined.

The chosen images are meant to expose specific faults:
- An all-zero image pins down the missing final inversion.
- Single-byte images show up any error in the interleave order.
- All-ones and alternating patterns drive the bit-3 mask and the leakage range.

A restart in the middle of a run, and a change on the input bus during a run, show that each result depends only on the image captured at the last start pulse.

// File: rtl/fuse_serial_gen.sv
module fuse_serial_gen #(
  parameter int          NBYTES = 32,
  parameter int          GRP    = 8,
  parameter logic [31:0] POLY   = 32'hEDB88320
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NBYTES*8-1:0] fuse_img,
  input  logic [1:0]          leak_sel,
  output logic [31:0]         serial_lo,
  output logic [31:0]         serial_hi,
  output logic [7:0]          fuse_ver,
  output logic [3:0]          proc_ver,
  output logic [1:0]          cpu_rev,
  output logic [7:0]          leak_val,
  output logic                valid
);
  localparam int NSTEP  = 2 * GRP;
  localparam int CW     = $clog2(NSTEP);
  localparam int A_BASE = GRP;
  localparam int B_BASE = GRP - 1;
  localparam int VERB   = 4;
  localparam int PROCB  = 6;
  localparam int LEAKB  = 23;

  logic [NBYTES*8-1:0] img_q;
  logic [CW-1:0]       step;
  logic                busy;
  logic [31:0]         crc_q, crc_nx;
  logic [7:0]          seq [NSTEP];
  logic                unused_img;

  for (genvar gi = 0; gi < GRP; gi++) begin : g_order
    assign seq[gi]       = img_q[8*(A_BASE + 2*gi) +: 8];
    assign seq[GRP + gi] = img_q[8*(B_BASE + 2*gi) +: 8];
  end

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  assign crc_nx = crc_step(crc_q, seq[step]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      img_q     <= '0;
      step      <= '0;
      busy      <= 1'b0;
      crc_q     <= '0;
      serial_lo <= '0;
      serial_hi <= '0;
      valid     <= 1'b0;
    end else if (start) begin
      img_q <= fuse_img;
      step  <= '0;
      busy  <= 1'b1;
      crc_q <= '0;
      valid <= 1'b0;
    end else if (busy) begin
      crc_q <= crc_nx;
      step  <= step + 1'b1;
      if (step == CW'(GRP - 1))
        serial_lo <= crc_nx;
      if (step == CW'(NSTEP - 1)) begin
        serial_hi <= crc_nx;
        busy      <= 1'b0;
        valid     <= 1'b1;
      end
    end
  end

  assign fuse_ver = img_q[8*VERB +: 8] & 8'hF7;
  assign proc_ver = img_q[8*PROCB +: 4];
  assign cpu_rev  = img_q[8*PROCB + 4 +: 2];

  always_comb begin
    case (leak_sel)
      2'd0:    leak_val = img_q[8*LEAKB +: 8];
      2'd1:    leak_val = img_q[8*(LEAKB + 1) +: 8];
      2'd2:    leak_val = img_q[8*(LEAKB + 2) +: 8];
      default: leak_val = 8'd0;
    endcase
  end

  assign unused_img = ^img_q;
endmodule

module fuse_serial_gen_chk #(
  parameter int GRP = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  leak_sel,
  input logic [31:0] serial_lo,
  input logic [31:0] serial_hi,
  input logic [7:0]  fuse_ver,
  input logic [3:0]  proc_ver,
  input logic [1:0]  cpu_rev,
  input logic [7:0]  leak_val,
  input logic        valid
);
  localparam int LAT = 2 * GRP + 1;
  logic [7:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n)                      win <= '0;
    else if (start)                  win <= 8'd1;
    else if (win != 0 && win < 8'hF0) win <= win + 8'd1;
  end

  AST_START_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !valid); // R6
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> win == 8'(LAT)); // R5
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start) |=> (valid && $stable(serial_lo) && $stable(serial_hi))); // R11
  AST_LEAK_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (leak_sel == 2'd3) |-> (leak_val == 8'd0)); // R9
  AST_FVER_BIT3_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !fuse_ver[3]); // R7
  AST_FIELDS_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(fuse_ver) && $stable(proc_ver) && $stable(cpu_rev))); // R10
endmodule

bind fuse_serial_gen fuse_serial_gen_chk #(.GRP(GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .leak_sel(leak_sel),
  .serial_lo(serial_lo), .serial_hi(serial_hi), .fuse_ver(fuse_ver),
  .proc_ver(proc_ver), .cpu_rev(cpu_rev), .leak_val(leak_val), .valid(valid)
);

// File: tb/tb_fuse_serial_gen.sv
module tb_fuse_serial_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [255:0] fuse_img = '0;
  logic [1:0]   leak_sel = 2'd0;
  logic [31:0]  serial_lo, serial_hi;
  logic [7:0]   fuse_ver, leak_val;
  logic [3:0]   proc_ver;
  logic [1:0]   cpu_rev;
  logic         valid;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fuse_serial_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fuse_img(fuse_img), .leak_sel(leak_sel),
    .serial_lo(serial_lo), .serial_hi(serial_hi), .fuse_ver(fuse_ver), .proc_ver(proc_ver),
    .cpu_rev(cpu_rev), .leak_val(leak_val), .valid(valid)
  );

  function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic logic [31:0] ref_group(input logic [31:0] seed, input logic [255:0] im, input int base);
    logic [31:0] c;
    c = seed;
    for (int i = 0; i < 8; i++) c = ref_step(c, im[8*(base + 2*i) +: 8]);
    return c;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk({31'd0, valid}, 32'd0, "R1 valid");
    chk(serial_lo, 32'd0, "R1 serial_lo");
    chk(serial_hi, 32'd0, "R1 serial_hi");
    chk({18'd0, fuse_ver, proc_ver, cpu_rev}, 32'd0, "R1 fields");
    chk({24'd0, leak_val}, 32'd0, "R1 leak");
  endtask

  task automatic t_run(input logic [255:0] im, input string tag);
    logic [31:0] lo, hi;
    @(negedge clk); fuse_img = im; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({31'd0, valid}, 32'd0, {"R6 valid low after start ", tag});
    fuse_img = ~im;
    repeat (15) @(negedge clk);
    chk({31'd0, valid}, 32'd0, {"R5 valid low at E15 ", tag});
    @(negedge clk);
    chk({31'd0, valid}, 32'd1, {"R5 valid high after E16 ", tag});
    lo = ref_group(32'd0, im, 8);
    hi = ref_group(lo, im, 7);
    chk(serial_lo, lo, {"R2 R4 serial_lo ", tag});
    chk(serial_hi, hi, {"R3 R4 serial_hi ", tag});
    chk({24'd0, fuse_ver}, {24'd0, im[39:32] & 8'hF7}, {"R7 fuse_ver ", tag});
    chk({28'd0, proc_ver}, {28'd0, im[51:48]}, {"R8 proc_ver ", tag});
    chk({30'd0, cpu_rev}, {30'd0, im[53:52]}, {"R8 cpu_rev ", tag});
    chk({24'd0, fuse_ver ^ (im[39:32] & 8'hF7)}, 32'd0, {"R10 fields from captured image ", tag});
    for (int s = 0; s < 4; s++) begin
      leak_sel = 2'(s); #1;
      chk({24'd0, leak_val}, (s < 3) ? {24'd0, im[8*(23+s) +: 8]} : 32'd0, {"R9 leak ", tag});
    end
    leak_sel = 2'd0;
  endtask

  task automatic t_hold;
    logic [31:0] lo, hi;
    lo = serial_lo; hi = serial_hi;
    fuse_img = {8{32'hDEADBEEF}};
    repeat (10) @(negedge clk);
    chk({31'd0, valid}, 32'd1, "R11 valid holds");
    chk(serial_lo, lo, "R11 serial_lo holds");
    chk(serial_hi, hi, "R11 R10 serial_hi holds");
  endtask

  task automatic t_restart(input logic [255:0] first, input logic [255:0] second);
    @(negedge clk); fuse_img = first; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    t_run(second, "restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_run('0, "zeros");
    t_run(256'd1 << 64, "byte8 only");
    t_run(256'd1 << 56, "byte7 only");
    t_run('1, "ones");
    t_hold;
    t_run({8{32'hA55A_3CC3}}, "pattern");
    t_restart({8{32'h1234_5678}}, {8{32'h0F1E_2D3C}});
    begin
      logic [255:0] im;
      for (int n = 0; n < 8; n++) begin
        im = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        t_run(im, "random");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule